// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers up to 29 level-sensitive interrupt sources into one interrupt line for a CPU. Each source owns one bit of a 32-bit cause word, at positions 1 through 29. A second 32-bit word holds per-source enables. The source bits ANDed with the enables form the pending set. A registered OR of the pending set drives the CPU interrupt pin.

The three spare positions of the cause word are filled by hardware summary bits. Each is an OR over a fixed, irregular group of source bits. Software reads both words over a small synchronous register bus. It acknowledges a source by writing a cause word with that bit at zero. A dispatch port gives the lowest-numbered pending source with a valid flag, so a handler can branch without scanning the word. When the valid flag is low, the interrupt is spurious.

Top module: `irqagg_top`

## Requirements
- R1: While source input j (j = 0..28) is high at a clock edge, cause bit j+1 reads 1 after that edge. A source still high after software clears its bit sets the bit again.
- R2: A write to the cause word (address 0) clears every source bit written as 0. Writing 1 to a bit leaves it unchanged. A source bit never becomes 1 except through its source.
- R3: When a source is high in the same cycle as a write that clears its bit, the bit reads 1 afterwards.
- R4: Cause bit 0 reads as the OR of cause bits 1 to 29.
- R5: Cause bit 30 reads as the OR of cause bits 26 to 29 and bits 1 to 20.
- R6: Cause bit 31 reads as the OR of cause bits 1 to 25. Bits 0, 30 and 31 ignore writes.
- R7: The enable word is at address 1. Bits 1 to 29 are writable, and a 1 enables the source. Bits 0, 30 and 31 read 0. Both words reset to zero under a synchronous active-low reset.
- R8: `irq_out` equals, one cycle later, the OR of (cause AND enable) over bits 1 to 29. It is 0 after reset.
- R9: `disp_valid` is 1 exactly when some source bit is both set and enabled. `disp_idx` then gives the lowest such position (1..29). With none pending, `disp_valid` is 0 and `disp_idx` is 0.
- R10: `bus_rdata` follows `bus_addr` combinationally, whether or not `bus_sel` is high. Addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 29 | Source levels; bit j maps to cause bit j+1 |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write when selected |
| bus_addr | input | 2 | Word address: 0 cause, 1 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Registered interrupt request to CPU |
| disp_valid | output | 1 | Some enabled source pending |
| disp_idx | output | 5 | Lowest pending enabled source number |

## Verification
A corrupted source bit shows on `bus_rdata` in the first cycle the cause word is addressed. It also shows on the dispatch pair in the same cycle if the source is enabled, and on `irq_out` one edge later. A wrong summary bit differs from the OR of the visible source bits in the same read. A lost or stuck enable bit shows on the address-1 read and as a changed dispatch index. The bench reads the registers at changing addresses every cycle and compares all outputs with a behavioural model. Each fault is therefore flagged within a few cycles of when it arises.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    // Bus geometry
    localparam int WORD_W = 32;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CAUSE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd1;

    // Source field inside the cause word
    localparam int SRC_LO = 1;
    localparam int SRC_HI = 29;

    // Summary bit positions and group boundaries
    localparam int SUM_ALL_POS  = 0;
    localparam int SUM_SPLIT_POS = 30;
    localparam int SUM_MID_POS  = 31;
    localparam int GRP_TOP_LO   = 26;
    localparam int GRP_LOW_HI   = 20;
    localparam int GRP_MID_HI   = 25;
endpackage

// File: rtl/irqagg_cause_bank.sv
// Holds the per-source cause bits and builds the read view with summary bits.
// Assumes sources are level signals sampled every clock; a set beats a clear.
module irqagg_cause_bank #(
    parameter int WORD_W      = irqagg_pkg::WORD_W,
    parameter int SRC_LO      = irqagg_pkg::SRC_LO,
    parameter int SRC_HI      = irqagg_pkg::SRC_HI,
    parameter int SUM_ALL_POS = irqagg_pkg::SUM_ALL_POS,
    parameter int SUM_SPLIT_POS = irqagg_pkg::SUM_SPLIT_POS,
    parameter int SUM_MID_POS = irqagg_pkg::SUM_MID_POS,
    parameter int GRP_TOP_LO  = irqagg_pkg::GRP_TOP_LO,
    parameter int GRP_LOW_HI  = irqagg_pkg::GRP_LOW_HI,
    parameter int GRP_MID_HI  = irqagg_pkg::GRP_MID_HI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] src_word,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] clr_data,
    output logic [WORD_W-1:0] cause_core,
    output logic [WORD_W-1:0] cause_view
);
    function automatic logic [WORD_W-1:0] span(input int hi, input int lo);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++)
            if (i >= lo && i <= hi) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] M_ALL   = span(SRC_HI, SRC_LO);
    localparam logic [WORD_W-1:0] M_SPLIT = span(SRC_HI, GRP_TOP_LO) | span(GRP_LOW_HI, SRC_LO);
    localparam logic [WORD_W-1:0] M_MID   = span(GRP_MID_HI, SRC_LO);

    genvar g;
    generate
        for (g = 0; g < WORD_W; g++) begin : g_bit
            if (g >= SRC_LO && g <= SRC_HI) begin : g_src
                // Latch a source level; clear on a written zero unless source is high
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        cause_core[g] <= 1'b0;
                    else if (src_word[g])
                        cause_core[g] <= 1'b1;
                    else if (clr_en && !clr_data[g])
                        cause_core[g] <= 1'b0;
                end
            end else begin : g_none
                assign cause_core[g] = 1'b0;
            end
        end
    endgenerate

    // Overlay the three summary ORs onto the unused positions
    always_comb begin
        cause_view                = cause_core;
        cause_view[SUM_ALL_POS]   = |(cause_core & M_ALL);
        cause_view[SUM_SPLIT_POS] = |(cause_core & M_SPLIT);
        cause_view[SUM_MID_POS]   = |(cause_core & M_MID);
    end
endmodule

// File: rtl/irqagg_mask_reg.sv
// Per-source enable register; only source positions are storable.
// Assumes a write is a full-word replacement of the enable bits.
module irqagg_mask_reg #(
    parameter int WORD_W = irqagg_pkg::WORD_W,
    parameter int SRC_LO = irqagg_pkg::SRC_LO,
    parameter int SRC_HI = irqagg_pkg::SRC_HI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] mask_core
);
    function automatic logic [WORD_W-1:0] field();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = SRC_LO; i <= SRC_HI; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] FIELD = field();

    // Replace enable bits on a write, keep them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_core <= '0;
        else if (wr_en)
            mask_core <= wr_data & FIELD;
    end
endmodule

// File: rtl/irqagg_prio_enc.sv
// Finds the lowest set position of the pending word within the source field.
// Assumes positions outside the field are never dispatched.
module irqagg_prio_enc #(
    parameter int WORD_W = irqagg_pkg::WORD_W,
    parameter int SRC_LO = irqagg_pkg::SRC_LO,
    parameter int SRC_HI = irqagg_pkg::SRC_HI,
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] pending,
    output logic              found,
    output logic [IDX_W-1:0]  index
);
    // Scan from the top so the lowest set bit is the last one written
    always_comb begin
        found = 1'b0;
        index = '0;
        for (int i = SRC_HI; i >= SRC_LO; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                index = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqagg_top.sv
// Interrupt aggregator: cause and enable words on a register bus, summary
// bits, registered CPU request and lowest-index dispatch. Synchronous reset.
module irqagg_top #(
    parameter int WORD_W = irqagg_pkg::WORD_W,
    parameter int ADDR_W = irqagg_pkg::ADDR_W,
    parameter int SRC_LO = irqagg_pkg::SRC_LO,
    parameter int SRC_HI = irqagg_pkg::SRC_HI,
    localparam int NSRC  = SRC_HI - SRC_LO + 1,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              disp_valid,
    output logic [IDX_W-1:0]  disp_idx
);
    import irqagg_pkg::*;

    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] cause_core;
    logic [WORD_W-1:0] cause_view;
    logic [WORD_W-1:0] mask_core;
    logic [WORD_W-1:0] pending;
    logic              wr_cause;
    logic              wr_mask;
    logic              irq_q;

    // Place source levels at their cause positions
    always_comb begin
        src_word = '0;
        src_word[SRC_HI:SRC_LO] = irq_src;
    end

    // Decode write strobes per register
    assign wr_cause = bus_sel && bus_wr && (bus_addr == ADDR_CAUSE);
    assign wr_mask  = bus_sel && bus_wr && (bus_addr == ADDR_MASK);

    irqagg_cause_bank #(
        .WORD_W(WORD_W), .SRC_LO(SRC_LO), .SRC_HI(SRC_HI),
        .SUM_ALL_POS(SUM_ALL_POS), .SUM_SPLIT_POS(SUM_SPLIT_POS),
        .SUM_MID_POS(SUM_MID_POS), .GRP_TOP_LO(GRP_TOP_LO),
        .GRP_LOW_HI(GRP_LOW_HI), .GRP_MID_HI(GRP_MID_HI)
    ) u_cause (
        .clk(clk), .rst_n(rst_n), .src_word(src_word),
        .clr_en(wr_cause), .clr_data(bus_wdata),
        .cause_core(cause_core), .cause_view(cause_view)
    );

    irqagg_mask_reg #(.WORD_W(WORD_W), .SRC_LO(SRC_LO), .SRC_HI(SRC_HI)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_mask),
        .wr_data(bus_wdata), .mask_core(mask_core)
    );

    // Enabled pending set
    assign pending = cause_core & mask_core;

    irqagg_prio_enc #(.WORD_W(WORD_W), .SRC_LO(SRC_LO), .SRC_HI(SRC_HI), .IDX_W(IDX_W)) u_prio (
        .pending(pending), .found(disp_valid), .index(disp_idx)
    );

    // Register the CPU request from the pending set
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |pending[SRC_HI:SRC_LO];
    end
    assign irq_out = irq_q;

    // Read multiplexer keyed by address only
    always_comb begin
        case (bus_addr)
            ADDR_CAUSE: bus_rdata = cause_view;
            ADDR_MASK:  bus_rdata = mask_core;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqagg_checker.sv
// Property checks for irqagg_top, attached by bind below.
module irqagg_checker #(
    parameter int WORD_W = irqagg_pkg::WORD_W,
    parameter int ADDR_W = irqagg_pkg::ADDR_W,
    parameter int SRC_LO = irqagg_pkg::SRC_LO,
    parameter int SRC_HI = irqagg_pkg::SRC_HI,
    localparam int NSRC  = SRC_HI - SRC_LO + 1,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   irq_src,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [WORD_W-1:0] cause_core,
    input logic [WORD_W-1:0] mask_core,
    input logic              irq_out,
    input logic              disp_valid,
    input logic [IDX_W-1:0]  disp_idx
);
    localparam logic [WORD_W-1:0] ONE = 1;

    logic [WORD_W-1:0] src_w;
    logic [WORD_W-1:0] pend;
    logic [WORD_W-1:0] below;

    always_comb begin
        src_w = '0;
        src_w[SRC_HI:SRC_LO] = irq_src;
    end
    assign pend  = cause_core & mask_core;
    assign below = (ONE << disp_idx) - ONE;

    p_level_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src != '0) |=> ((cause_core & $past(src_w)) == $past(src_w)));

    p_no_spont_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_core & ~$past(cause_core) & ~$past(src_w)) == '0));

    p_sum_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == irqagg_pkg::ADDR_CAUSE) |-> (bus_rdata[0] == (|bus_rdata[SRC_HI:SRC_LO])));

    p_mask_spare_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == irqagg_pkg::ADDR_MASK) |-> (bus_rdata[0] == 1'b0 && bus_rdata[WORD_W-1:SRC_HI+1] == '0));

    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> irq_out);

    p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |=> !irq_out);

    p_disp_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (pend[disp_idx] && (pend & below) == '0));

    p_disp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |-> (disp_idx == '0 && pend == '0));
endmodule

bind irqagg_top irqagg_checker #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SRC_LO(SRC_LO), .SRC_HI(SRC_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .cause_core(cause_core), .mask_core(mask_core),
    .irq_out(irq_out), .disp_valid(disp_valid), .disp_idx(disp_idx)
);

// File: tb/irqagg_top_test.sv
module irqagg_top_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FIELD = 32'h3FFF_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic        disp_valid;
    logic [4:0]  disp_idx;

    int vectors = 0;
    int fails = 0;

    // Reference model state
    logic [31:0] m_cause = '0;
    logic [31:0] m_mask = '0;
    logic        m_irq = 1'b0;

    irqagg_top uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out), .disp_valid(disp_valid),
        .disp_idx(disp_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model advanced on each rising edge
    always @(posedge clk) begin
        logic [31:0] sw, nc, nm;
        logic        ni;
        sw = {2'b00, irq_src, 1'b0};
        if (!rst_n) begin
            nc = '0; nm = '0; ni = 1'b0;
        end else begin
            ni = ((m_cause & m_mask & FIELD) != 0);
            nc = m_cause;
            if (bus_sel && bus_wr && bus_addr == 2'd0) nc = nc & bus_wdata;
            nc = (nc | sw) & FIELD;
            nm = m_mask;
            if (bus_sel && bus_wr && bus_addr == 2'd1) nm = bus_wdata & FIELD;
        end
        m_cause = nc; m_mask = nm; m_irq = ni;
    end

    function automatic logic [31:0] view(input logic [31:0] c);
        logic [31:0] v;
        v = c & FIELD;
        v[0] = 1'b0; v[30] = 1'b0; v[31] = 1'b0;
        for (int i = 1; i <= 29; i++) begin
            if (c[i]) begin
                v[0] = 1'b1;
                if (i >= 26 || i <= 20) v[30] = 1'b1;
                if (i <= 25) v[31] = 1'b1;
            end
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic check_all();
        logic [31:0] v;
        logic [31:0] p;
        int idx;
        v = view(m_cause);
        if (bus_addr == 2'd0) begin
            chk("R1 R2 R3 cause source bits", bus_rdata & FIELD, v & FIELD);
            chk("R4 bit0 summary", {31'b0, bus_rdata[0]}, {31'b0, v[0]});
            chk("R5 bit30 summary", {31'b0, bus_rdata[30]}, {31'b0, v[30]});
            chk("R6 bit31 summary", {31'b0, bus_rdata[31]}, {31'b0, v[31]});
        end else if (bus_addr == 2'd1) begin
            chk("R7 enable word", bus_rdata, m_mask);
        end else begin
            chk("R10 unmapped read", bus_rdata, 32'h0);
        end
        chk("R8 irq_out", {31'b0, irq_out}, {31'b0, m_irq});
        p = m_cause & m_mask & FIELD;
        idx = 0;
        for (int i = 29; i >= 1; i--) if (p[i]) idx = i;
        chk("R9 disp_valid", {31'b0, disp_valid}, {31'b0, (p != 0)});
        chk("R9 disp_idx", {27'b0, disp_idx}, idx);
    endtask

    // One cycle: drive at falling edge, check at the next falling edge
    task automatic cyc(input logic [28:0] s, input logic sel, input logic wr,
                       input logic [1:0] a, input logic [31:0] d);
        irq_src = s; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        check_all();
    endtask

    task automatic rd(input logic [1:0] a);
        cyc('0, 1'b0, 1'b0, a, '0);
    endtask

    function automatic logic [28:0] bit_of(input int n);
        return 29'(1) << (n - 1);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Reset: both words zero (R7), irq low (R8), no dispatch (R9)
        cyc(29'h1FFF_FFFF, 1'b0, 1'b0, 2'd0, '0);
        cyc('0, 1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        rd(2'd0); rd(2'd1);
        // R7: enable all, spare bits read zero
        cyc('0, 1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF);
        rd(2'd1);
        // R1: single-cycle pulse on source 5 latches
        cyc(bit_of(5), 1'b0, 1'b0, 2'd0, '0);
        rd(2'd0); rd(2'd0);
        // R2: writing ones has no effect, summary bits ignore writes (R6)
        cyc('0, 1'b1, 1'b1, 2'd0, 32'hFFFF_FFFF);
        rd(2'd0);
        // R2: writing zero at bit 5 clears it
        cyc('0, 1'b1, 1'b1, 2'd0, ~32'h20);
        rd(2'd0);
        // R3: held source wins over a same-cycle clear; R1 re-set after clear
        cyc(bit_of(7), 1'b1, 1'b1, 2'd0, 32'h0);
        cyc(bit_of(7), 1'b1, 1'b1, 2'd0, 32'h0);
        cyc('0, 1'b1, 1'b1, 2'd0, 32'h0);
        rd(2'd0);
        // R5: only the top group (bit 27) sets bit 30, not bit 31
        cyc(bit_of(27), 1'b0, 1'b0, 2'd0, '0);
        rd(2'd0);
        cyc('0, 1'b1, 1'b1, 2'd0, 32'h0);
        // R6: bit 22 sets bit 31 but not bit 30
        cyc(bit_of(22), 1'b0, 1'b0, 2'd0, '0);
        rd(2'd0);
        cyc('0, 1'b1, 1'b1, 2'd0, 32'h0);
        // R4: bit 3 sets all three summary bits; bit 29 alone
        cyc(bit_of(3), 1'b0, 1'b0, 2'd0, '0);
        cyc(bit_of(29), 1'b1, 1'b1, 2'd0, 32'h0);
        rd(2'd0);
        cyc('0, 1'b1, 1'b1, 2'd0, 32'h0);
        // R9: lowest of 9 and 4 wins, then masking 4 moves dispatch to 9
        cyc(bit_of(9) | bit_of(4), 1'b0, 1'b0, 2'd0, '0);
        rd(2'd0);
        cyc('0, 1'b1, 1'b1, 2'd1, ~32'h10);
        rd(2'd1);
        // R8: disabling all drops irq one cycle later
        cyc('0, 1'b1, 1'b1, 2'd1, 32'h0);
        rd(2'd0); rd(2'd0);
        // R10: unmapped addresses read zero and writes there do nothing
        cyc('0, 1'b1, 1'b1, 2'd2, 32'hFFFF_FFFF);
        cyc('0, 1'b1, 1'b1, 2'd3, 32'h0);
        rd(2'd1); rd(2'd0);
        // Mixed traffic with sparse sources
        for (int k = 0; k < 600; k++) begin
            logic [28:0] s;
            logic [31:0] d;
            int op;
            s = 29'($urandom & $urandom & $urandom);
            if ($urandom % 3 == 0) s = '0;
            d = $urandom;
            op = $urandom % 6;
            case (op)
                0: cyc(s, 1'b1, 1'b1, 2'd0, d);
                1: cyc(s, 1'b1, 1'b1, 2'd1, d);
                2: cyc(s, 1'b1, 1'b1, 2'($urandom % 4), d);
                default: cyc(s, 1'($urandom % 2), 1'b0, 2'($urandom % 4), d);
            endcase
        end
        // Mid-run reset returns to zero state
        rst_n = 1'b0;
        rd(2'd0);
        rst_n = 1'b1;
        rd(2'd0); rd(2'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule